// File: doc/BRIEF.md
# Dual-Port Memory with Same-Address Collision Arbitration

This block is a synchronous memory, 4096 words of 16 bits by default, with two fully independent ports, called left and right. Each port has its own enable, write strobe, address, write data and registered read data, and either port may reach every location. When both ports are enabled on the same address in the same cycle, an arbiter lets one port proceed and raises a busy flag toward the other. Any write carried by the flagged port is suppressed inside the block. A read by the flagged port still returns data, so for a reader busy is only a warning.

A mode input selects how busy works. In master mode the block computes busy for each port from the enables and addresses alone. Whether either port reads or writes has no effect on the decision. In slave mode the internal arbiter is switched off and the busy outputs stay low. Each port then takes a busy input from outside, which acts purely as a write inhibit for that port. Several slave instances placed side by side for a wider word can therefore follow the decision made by a single master.

On a fresh collision the left port wins. The right port wins only when it already held that same address, unflagged, in the previous cycle and is still presenting it.

Top module: `dpc_collision_ram`

## Requirements
- R1: In master mode (`master_mode`=1), when both ports are enabled on equal addresses, exactly one of `lf_busy_out`/`rt_busy_out` is 1 in that same cycle. When either port is disabled or the addresses differ, both are 0.
- R2: The busy decision does not depend on `lf_wr` or `rt_wr`. A read on one port still collides with a read or a write on the other.
- R3: On a collision where neither port is the incumbent, the left port wins: `lf_busy_out`=0 and `rt_busy_out`=1.
- R4: The right port is the incumbent, and wins (`lf_busy_out`=1, `rt_busy_out`=0), when in the previous master-mode cycle it was enabled and not busy on the same address it presents now.
- R5: A write from the port whose busy is 1 leaves the memory unchanged. The winning port's write is stored.
- R6: A port flagged busy that is reading still receives the stored word on its read data one cycle later.
- R7: In slave mode (`master_mode`=0) both busy outputs are 0. A port's busy input at 1 blocks that port's writes, and at 0 its writes proceed normally.
- R8: In master mode the busy inputs have no effect.
- R9: In slave mode, when both ports write the same address with neither inhibited, the left port's data is stored.
- R10: Addresses 0 through 4095 are all usable. Read data appears on the clock edge after an enabled access and is read-before-write. Reset (`rst_n`=0) clears both read data outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_mode | input | 1 | 1 = arbiter computes busy; 0 = busy inputs act as write inhibits |
| lf_en | input | 1 | Left port enable |
| lf_wr | input | 1 | Left port write strobe |
| lf_addr | input | 12 | Left port word address |
| lf_wdata | input | 16 | Left port write data |
| lf_rdata | output | 16 | Left port read data, registered |
| lf_busy_in | input | 1 | Left write inhibit, used in slave mode |
| lf_busy_out | output | 1 | Left busy flag, driven in master mode |
| rt_en | input | 1 | Right port enable |
| rt_wr | input | 1 | Right port write strobe |
| rt_addr | input | 12 | Right port word address |
| rt_wdata | input | 16 | Right port write data |
| rt_rdata | output | 16 | Right port read data, registered |
| rt_busy_in | input | 1 | Right write inhibit, used in slave mode |
| rt_busy_out | output | 1 | Right busy flag, driven in master mode |

## Verification
The bench aims at the incumbency rule. A right port that holds an address, with a left access then landing on it, must keep its grant. A design that always favours the left port would instead corrupt the right port's data. It checks that a pure read collides with a write, which catches a design that arbitrates only writes. It also forces the busy inputs high in master mode and low in slave mode, exposing a mode mux that is wired backwards. Finally, it reads back every written word and checks the left-data-wins rule for a same-address double write in slave mode, plus the first and last addresses. This catches writes that leak through an inhibit and truncated address decoding.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
   localparam int NPORT = 2;
   localparam int PORT_LF = 0;
   localparam int PORT_RT = 1;
   typedef enum logic {
      MODE_SLAVE  = 1'b0,
      MODE_MASTER = 1'b1
   } arb_mode_e;
endpackage

// File: rtl/dpc_collision_arb.sv
module dpc_collision_arb #(
   parameter int ADDR_W       = 12,
   parameter bit LEFT_DEFAULT = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          master,
   input  logic [1:0]                    en,
   input  logic [1:0][ADDR_W-1:0]        addr,
   output logic [1:0]                    busy
);
   import dpc_pkg::*;

   logic [1:0]             own_q;
   logic [1:0][ADDR_W-1:0] addr_q;
   logic [1:0]             senior;
   logic                   same_addr;
   logic                   clash;
   logic                   hist_ok_q;

   assign same_addr = (addr[PORT_LF] == addr[PORT_RT]);
   assign clash     = master & en[PORT_LF] & en[PORT_RT] & same_addr;

   for (genvar p = 0; p < NPORT; p++) begin : g_senior
      assign senior[p] = own_q[p] & en[p] & (addr[p] == addr_q[p]);
   end

   if (LEFT_DEFAULT) begin : g_left_tie
      assign busy[PORT_LF] = clash &  senior[PORT_RT];
      assign busy[PORT_RT] = clash & ~senior[PORT_RT];
   end else begin : g_right_tie
      assign busy[PORT_RT] = clash &  senior[PORT_LF];
      assign busy[PORT_LF] = clash & ~senior[PORT_LF];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q     <= '0;
         addr_q    <= '0;
         hist_ok_q <= 1'b0;
      end else begin
         own_q     <= master ? (en & ~busy) : 2'b00;
         addr_q    <= addr;
         hist_ok_q <= 1'b1;
      end
   end

   // R1: a same-address meeting in master mode flags exactly one port
   assert_one_loser_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (master && en[0] && en[1] && addr[0] == addr[1]) |-> ($countones(busy) == 1));

   // R1: no busy without both enables and matching addresses
   assert_no_false_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!master || !en[0] || !en[1] || addr[0] != addr[1]) |-> (busy == 2'b00));

   // R4: a right port that held the address unflagged keeps its grant
   assert_incumbent_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hist_ok_q && master && $past(master) && en[0] && en[1] && addr[0] == addr[1]
       && $past(en[1] && !busy[1]) && addr[1] == $past(addr[1])) |-> !busy[1]);
endmodule

// File: rtl/dpc_write_gate.sv
module dpc_write_gate (
   input  logic en,
   input  logic wr,
   input  logic inhibit,
   output logic we
);
   assign we = en & wr & ~inhibit;
endmodule

// File: rtl/dpc_dual_store.sv
module dpc_dual_store #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             en,
   input  logic [1:0]             we,
   input  logic [1:0][ADDR_W-1:0] addr,
   input  logic [1:0][DATA_W-1:0] wdata,
   output logic [1:0][DATA_W-1:0] rdata
);
   import dpc_pkg::*;
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // right first, left last: the left port's value survives a double write
   always_ff @(posedge clk) begin
      if (we[PORT_RT]) mem[addr[PORT_RT]] <= wdata[PORT_RT];
      if (we[PORT_LF]) mem[addr[PORT_LF]] <= wdata[PORT_LF];
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_rd
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     rdata[p] <= '0;
         else if (en[p]) rdata[p] <= mem[addr[p]];
      end
   end

   // R9: simultaneous writes to one word keep the left data
   assert_left_data_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (we[0] && we[1] && addr[0] == addr[1]) |=> (mem[$past(addr[0])] === $past(wdata[0])));
endmodule

// File: rtl/dpc_collision_ram.sv
module dpc_collision_ram #(
   parameter int ADDR_W       = 12,
   parameter int DATA_W       = 16,
   parameter bit LEFT_DEFAULT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_mode,
   input  logic              lf_en,
   input  logic              lf_wr,
   input  logic [ADDR_W-1:0] lf_addr,
   input  logic [DATA_W-1:0] lf_wdata,
   output logic [DATA_W-1:0] lf_rdata,
   input  logic              lf_busy_in,
   output logic              lf_busy_out,
   input  logic              rt_en,
   input  logic              rt_wr,
   input  logic [ADDR_W-1:0] rt_addr,
   input  logic [DATA_W-1:0] rt_wdata,
   output logic [DATA_W-1:0] rt_rdata,
   input  logic              rt_busy_in,
   output logic              rt_busy_out
);
   import dpc_pkg::*;

   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr_w
      $error("dpc_collision_ram: ADDR_W must lie in 1..16");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("dpc_collision_ram: DATA_W must be at least 1");
   end

   arb_mode_e              mode;
   logic [1:0]             en, wr, busy_ext, arb_busy, inhibit, we;
   logic [1:0][ADDR_W-1:0] addr;
   logic [1:0][DATA_W-1:0] wdata, rdata;

   assign mode     = arb_mode_e'(master_mode);
   assign en       = {rt_en, lf_en};
   assign wr       = {rt_wr, lf_wr};
   assign addr     = {rt_addr, lf_addr};
   assign wdata    = {rt_wdata, lf_wdata};
   assign busy_ext = {rt_busy_in, lf_busy_in};

   dpc_collision_arb #(.ADDR_W(ADDR_W), .LEFT_DEFAULT(LEFT_DEFAULT)) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .master (mode == MODE_MASTER),
      .en     (en),
      .addr   (addr),
      .busy   (arb_busy)
   );

   assign inhibit = (mode == MODE_MASTER) ? arb_busy : busy_ext;

   for (genvar p = 0; p < NPORT; p++) begin : g_gate
      dpc_write_gate u_gate (
         .en      (en[p]),
         .wr      (wr[p]),
         .inhibit (inhibit[p]),
         .we      (we[p])
      );
   end

   dpc_dual_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .we    (we),
      .addr  (addr),
      .wdata (wdata),
      .rdata (rdata)
   );

   assign lf_rdata    = rdata[PORT_LF];
   assign rt_rdata    = rdata[PORT_RT];
   assign lf_busy_out = arb_busy[PORT_LF];
   assign rt_busy_out = arb_busy[PORT_RT];

   // R7: busy outputs stay low in slave mode
   assert_slave_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !master_mode |-> (!lf_busy_out && !rt_busy_out));

   // R5: a flagged right write does not alter a word the left port only reads
   assert_loser_write_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (master_mode && rt_en && rt_wr && rt_busy_out && !lf_wr)
      |=> (u_store.mem[$past(rt_addr)] === $past(u_store.mem[rt_addr])));

   // R8: an unflagged left write lands in master mode whatever the busy input says
   assert_master_ignores_inhibit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (master_mode && lf_en && lf_wr && lf_busy_in && !lf_busy_out)
      |=> (u_store.mem[$past(lf_addr)] === $past(lf_wdata)));
endmodule

// File: tb/sim_dpc_collision_ram.sv
module sim_dpc_collision_ram;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 15;

   typedef struct packed {
      logic m;
      logic le, lw; logic [11:0] la; logic [15:0] ld;
      logic re, rw; logic [11:0] ra; logic [15:0] rd;
      logic bil, bir;
      logic xbl, xbr;
   } vec_t;

   // rows run back to back: incumbency carries from one row to the next
   localparam vec_t VEC [NVEC] = '{
      '{1'b1, 1'b1,1'b1,12'h010,16'hAAAA, 1'b1,1'b1,12'h020,16'hBBBB, 1'b0,1'b0, 1'b0,1'b0},
      '{1'b1, 1'b1,1'b1,12'h030,16'h1111, 1'b1,1'b1,12'h030,16'h2222, 1'b0,1'b0, 1'b0,1'b1},
      '{1'b1, 1'b0,1'b0,12'h000,16'h0000, 1'b0,1'b0,12'h000,16'h0000, 1'b0,1'b0, 1'b0,1'b0},
      '{1'b1, 1'b0,1'b0,12'h040,16'h0000, 1'b1,1'b1,12'h040,16'h3333, 1'b0,1'b0, 1'b0,1'b0},
      '{1'b1, 1'b1,1'b1,12'h040,16'h5555, 1'b1,1'b1,12'h040,16'h4444, 1'b0,1'b0, 1'b1,1'b0},
      '{1'b1, 1'b1,1'b1,12'h050,16'h7777, 1'b0,1'b0,12'h000,16'h0000, 1'b0,1'b0, 1'b0,1'b0},
      '{1'b1, 1'b1,1'b0,12'h050,16'h0000, 1'b1,1'b1,12'h050,16'h6666, 1'b0,1'b0, 1'b0,1'b1},
      '{1'b1, 1'b1,1'b1,12'h060,16'h0C0C, 1'b0,1'b0,12'h000,16'h0000, 1'b0,1'b0, 1'b0,1'b0},
      '{1'b0, 1'b1,1'b1,12'h060,16'h8888, 1'b1,1'b1,12'h061,16'h9999, 1'b1,1'b0, 1'b0,1'b0},
      '{1'b0, 1'b1,1'b1,12'h070,16'hABCD, 1'b1,1'b1,12'h070,16'hDCBA, 1'b0,1'b0, 1'b0,1'b0},
      '{1'b0, 1'b1,1'b1,12'h010,16'h1234, 1'b1,1'b1,12'h020,16'h5678, 1'b1,1'b1, 1'b0,1'b0},
      '{1'b1, 1'b1,1'b1,12'h080,16'h0F0F, 1'b1,1'b1,12'h081,16'hF0F0, 1'b1,1'b1, 1'b0,1'b0},
      '{1'b1, 1'b1,1'b1,12'hFFF,16'hFEED, 1'b1,1'b1,12'h000,16'hBEEF, 1'b0,1'b0, 1'b0,1'b0},
      '{1'b1, 1'b1,1'b1,12'hFFF,16'h0001, 1'b0,1'b0,12'hFFF,16'h0000, 1'b0,1'b0, 1'b0,1'b0},
      '{1'b1, 1'b0,1'b0,12'h000,16'h0000, 1'b0,1'b0,12'h000,16'h0000, 1'b0,1'b0, 1'b0,1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic master_mode = 1'b1;
   logic lf_en = 1'b0, lf_wr = 1'b0, lf_busy_in = 1'b0;
   logic rt_en = 1'b0, rt_wr = 1'b0, rt_busy_in = 1'b0;
   logic [11:0] lf_addr = '0, rt_addr = '0;
   logic [15:0] lf_wdata = '0, rt_wdata = '0;
   logic [15:0] lf_rdata, rt_rdata;
   logic lf_busy_out, rt_busy_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dpc_collision_ram u0 (
      .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
      .lf_en(lf_en), .lf_wr(lf_wr), .lf_addr(lf_addr), .lf_wdata(lf_wdata),
      .lf_rdata(lf_rdata), .lf_busy_in(lf_busy_in), .lf_busy_out(lf_busy_out),
      .rt_en(rt_en), .rt_wr(rt_wr), .rt_addr(rt_addr), .rt_wdata(rt_wdata),
      .rt_rdata(rt_rdata), .rt_busy_in(rt_busy_in), .rt_busy_out(rt_busy_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // both ports read; busy checked before the edge, data one edge later
   task automatic read_pair(input logic [11:0] la, input logic [11:0] ra,
                            input logic [15:0] xl, input logic [15:0] xr,
                            input logic xbl, input logic xbr, input string tag);
      @(negedge clk);
      master_mode = 1'b1;
      lf_en = 1'b1; lf_wr = 1'b0; lf_addr = la;
      rt_en = 1'b1; rt_wr = 1'b0; rt_addr = ra;
      #1;
      chk({tag, " lf busy"}, 32'(lf_busy_out), 32'(xbl));
      chk({tag, " rt busy"}, 32'(rt_busy_out), 32'(xbr));
      @(negedge clk);
      chk({tag, " lf data"}, 32'(lf_rdata), 32'(xl));
      chk({tag, " rt data"}, 32'(rt_rdata), 32'(xr));
      lf_en = 1'b0; rt_en = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
   end

   initial begin
      // R10: reset state
      repeat (3) @(negedge clk);
      chk("R10 reset lf_rdata", 32'(lf_rdata), 32'h0);
      chk("R10 reset rt_rdata", 32'(rt_rdata), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk("R1 idle busy", {30'b0, lf_busy_out, rt_busy_out}, 32'h0);

      // table walk: R1 R2 R3 R4 R7 R8 busy decisions
      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         master_mode = VEC[i].m;
         lf_en = VEC[i].le; lf_wr = VEC[i].lw; lf_addr = VEC[i].la; lf_wdata = VEC[i].ld;
         rt_en = VEC[i].re; rt_wr = VEC[i].rw; rt_addr = VEC[i].ra; rt_wdata = VEC[i].rd;
         lf_busy_in = VEC[i].bil; rt_busy_in = VEC[i].bir;
         #1;
         chk($sformatf("R1/R3/R4/R7 row %0d busy {lf,rt}", i),
             {30'b0, lf_busy_out, rt_busy_out}, {30'b0, VEC[i].xbl, VEC[i].xbr});
      end
      @(negedge clk);
      lf_en = 1'b0; rt_en = 1'b0; lf_busy_in = 1'b0; rt_busy_in = 1'b0;

      // read back the stored words
      read_pair(12'h010, 12'h020, 16'hAAAA, 16'hBBBB, 1'b0, 1'b0, "R7 inhibited slave writes kept");
      read_pair(12'h040, 12'h050, 16'h4444, 16'h7777, 1'b0, 1'b0, "R4/R2/R5 incumbent and reader win");
      read_pair(12'h060, 12'h061, 16'h0C0C, 16'h9999, 1'b0, 1'b0, "R7 per-port inhibit");
      read_pair(12'h070, 12'h080, 16'hABCD, 16'h0F0F, 1'b0, 1'b0, "R9/R8 left data, master ignores inhibit");
      read_pair(12'h081, 12'hFFF, 16'hF0F0, 16'h0001, 1'b0, 1'b0, "R8/R10 right write and top address");
      read_pair(12'h000, 12'h010, 16'hBEEF, 16'hAAAA, 1'b0, 1'b0, "R10 address zero");
      // R6 R3 R5: fresh read collision, loser still gets data; right write at 30 was blocked
      read_pair(12'h030, 12'h030, 16'h1111, 16'h1111, 1'b0, 1'b1, "R6/R3/R5 read collision");
      // R4: right held 30 unflagged? no, it was busy; left keeps winning on a repeat
      read_pair(12'h030, 12'h030, 16'h1111, 16'h1111, 1'b0, 1'b1, "R4 busy right gains no incumbency");

      // R10: read-before-write on one port
      @(negedge clk);
      lf_en = 1'b1; lf_wr = 1'b1; lf_addr = 12'h0A0; lf_wdata = 16'h1357;
      @(negedge clk);
      lf_wdata = 16'h2468;
      @(negedge clk);
      chk("R10 read-before-write", 32'(lf_rdata), 32'h1357);
      lf_en = 1'b0; lf_wr = 1'b0;

      finish_run();
   end
endmodule